// File: doc/BRIEF.md
# Posted Write Buffer for a Rotating Sliced Memory

This block sits between one client port and a word-interleaved memory whose slices are visited in turn by a rotating access window. The window reaches a given slice only once per rotation, so how long a direct write takes depends on the address. The buffer removes that variation. It takes an address, data and byte enables from the client in the cycle they are offered, holds them in a single entry, and commits them when the memory side reports that the slice owning that word is in front of the client. Because of this, a client that writes no more often than once per rotation sees every write complete in one cycle.

A second write offered while the entry is still occupied stalls the client. The stall lasts until the cycle in which the entry commits, and the new write is taken in that same cycle. Reads issued by the same client are compared against the held entry so that stale memory contents are never returned. A hit on an entry with all byte lanes written is answered from the entry. A hit on a partly written entry stalls the client until the entry has drained. The read path to the memory is not part of this block.

Top module: `hub_post_wbuf`

## Requirements
- R1: After a write is accepted, `pending` is 1 in the next cycle, and `cm_addr`, `cm_data` and `cm_be` hold that write's values unchanged until the cycle in which it commits.
- R2: A write offered while `pending` is 0, with no read stall in that cycle, is accepted with `stall` at 0 in the same cycle.
- R3: While `hub_slice` advances by one each cycle (modulo the slice count), a held write commits within one full rotation, so writes spaced at least one rotation apart never see `stall`.
- R4: A write offered while `pending` is 1 and no commit occurs in that cycle raises `stall` in that cycle, and the held entry is left unchanged.
- R5: `commit` is 1 in exactly the cycles in which `pending` is 1 and `hub_slice` equals the slice field `cm_addr[5:2]`. If no new write is accepted in a commit cycle, `pending` is 0 in the next cycle.
- R6: In a commit cycle, an offered write is accepted with `stall` at 0, and the entry holds the new write in the next cycle.
- R7: A read whose word address (`rd_addr[15:2]`) matches the held entry while `pending` is 1 and all four byte enables of the entry are set raises `fwd_hit` with `fwd_data` equal to the held data, and does not stall.
- R8: A read that matches the held word while at least one byte enable of the entry is clear raises `stall` and keeps `fwd_hit` at 0.
- R9: A read to any other word, or while `pending` is 0, raises neither `fwd_hit` nor `stall`.
- R10: Synchronous reset (active high) clears `pending`, and `commit` stays 0 while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Client write request |
| wr_addr | input | 16 | Byte address of the write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables of the write |
| rd_req | input | 1 | Client read request (for the hazard check only) |
| rd_addr | input | 16 | Byte address of the read |
| stall | output | 1 | Client must hold its request this cycle |
| fwd_hit | output | 1 | Read is answered from the held entry |
| fwd_data | output | 32 | Forwarded data |
| hub_slice | input | 4 | Slice currently served by the rotating window |
| commit | output | 1 | Held write is written to memory this cycle |
| cm_addr | output | 16 | Address of the held write |
| cm_data | output | 32 | Data of the held write |
| cm_be | output | 4 | Byte enables of the held write |
| pending | output | 1 | The entry holds a write that has not yet committed |

## Verification
The hardest situation to reach is a cycle in which the held write commits and a new write is offered at the same time, because it depends on where the rotating slice is when the client acts. The bench drives the slice counter itself, so directed sequences place the second write exactly on the commit cycle, one cycle before it, and one cycle after it. Random traffic then mixes back-to-back writes, reads aimed at the held word with full and partial byte enables, and periods where the slice jumps at random.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  // Outcome of comparing a client read with the held entry.
  typedef enum logic [1:0] {
    RD_MISS = 2'd0,
    RD_FWD  = 2'd1,
    RD_WAIT = 2'd2
  } rd_kind_e;

endpackage

// File: rtl/pwb_entry.sv
module pwb_entry #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                drain,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [DATA_W/8-1:0] in_be,
  output logic                valid,
  output logic [ADDR_W-1:0]   ent_addr,
  output logic [DATA_W-1:0]   ent_data,
  output logic [DATA_W/8-1:0] ent_be
);
  localparam int LANES = DATA_W / 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      ent_addr <= in_addr;
      ent_be   <= in_be;
    end
  end

  // One register per byte lane; all lanes are captured so that
  // forwarding always sees the full word presented with the write.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (load) begin
        ent_data[g*8 +: 8] <= in_data[g*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/pwb_match.sv
module pwb_match
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int NUM_SLICES = 16
) (
  input  logic                          valid,
  input  logic [ADDR_W-1:0]             ent_addr,
  input  logic [DATA_W/8-1:0]           ent_be,
  input  logic [$clog2(NUM_SLICES)-1:0] hub_slice,
  input  logic                          rd_req,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic                          slot_hit,
  output rd_kind_e                      rd_kind
);
  localparam int BE_W     = DATA_W / 8;
  localparam int LANE_LSB = $clog2(BE_W);
  localparam int SLICE_W  = $clog2(NUM_SLICES);

  logic word_eq;
  logic all_lanes;
  logic unused_rd_lo;

  assign unused_rd_lo = ^rd_addr[LANE_LSB-1:0];

  // The owning slice is the word-index field just above the byte lanes.
  assign slot_hit  = valid && (hub_slice == ent_addr[LANE_LSB +: SLICE_W]);
  assign word_eq   = rd_addr[ADDR_W-1:LANE_LSB] == ent_addr[ADDR_W-1:LANE_LSB];
  assign all_lanes = &ent_be;

  always_comb begin
    rd_kind = RD_MISS;
    if (rd_req && valid && word_eq) begin
      rd_kind = all_lanes ? RD_FWD : RD_WAIT;
    end
  end

endmodule

// File: rtl/hub_post_wbuf.sv
module hub_post_wbuf
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int NUM_SLICES = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_req,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [DATA_W/8-1:0]           wr_be,
  input  logic                          rd_req,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic                          stall,
  output logic                          fwd_hit,
  output logic [DATA_W-1:0]             fwd_data,
  input  logic [$clog2(NUM_SLICES)-1:0] hub_slice,
  output logic                          commit,
  output logic [ADDR_W-1:0]             cm_addr,
  output logic [DATA_W-1:0]             cm_data,
  output logic [DATA_W/8-1:0]           cm_be,
  output logic                          pending
);
  localparam int BE_W = DATA_W / 8;

  logic     slot_hit;
  rd_kind_e rd_kind;
  logic     wr_blocked;
  logic     rd_blocked;
  logic     take;

  pwb_match #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_SLICES(NUM_SLICES)
  ) u_match (
    .valid    (pending),
    .ent_addr (cm_addr),
    .ent_be   (cm_be),
    .hub_slice(hub_slice),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .slot_hit (slot_hit),
    .rd_kind  (rd_kind)
  );

  // A busy entry only blocks a write if it is not leaving this cycle.
  assign wr_blocked = wr_req && pending && !slot_hit;
  assign rd_blocked = (rd_kind == RD_WAIT);
  assign stall      = wr_blocked || rd_blocked;
  assign take       = wr_req && !stall;
  assign commit     = slot_hit;
  assign fwd_hit    = (rd_kind == RD_FWD);
  assign fwd_data   = cm_data;

  pwb_entry #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_entry (
    .clk     (clk),
    .rst     (rst),
    .load    (take),
    .drain   (slot_hit),
    .in_addr (wr_addr),
    .in_data (wr_data),
    .in_be   (wr_be[BE_W-1:0]),
    .valid   (pending),
    .ent_addr(cm_addr),
    .ent_data(cm_data),
    .ent_be  (cm_be)
  );

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int NUM_SLICES = 16
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_req,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [DATA_W-1:0]             wr_data,
  input logic                          rd_req,
  input logic [ADDR_W-1:0]             rd_addr,
  input logic                          stall,
  input logic                          fwd_hit,
  input logic [$clog2(NUM_SLICES)-1:0] hub_slice,
  input logic                          commit,
  input logic [ADDR_W-1:0]             cm_addr,
  input logic [DATA_W-1:0]             cm_data,
  input logic [DATA_W/8-1:0]           cm_be,
  input logic                          pending
);
  localparam int LANE_LSB = $clog2(DATA_W / 8);
  localparam int SLICE_W  = $clog2(NUM_SLICES);
  localparam int AGE_W    = SLICE_W + 2;

  logic               took;
  logic [SLICE_W-1:0] prev_slice;
  logic               steady_q;
  logic               steady_now;
  logic [AGE_W-1:0]   age;
  logic               rd_same;

  assign took       = wr_req && !stall;
  assign steady_now = steady_q && (hub_slice == prev_slice + 1'b1);
  assign rd_same    = rd_addr[ADDR_W-1:LANE_LSB] == cm_addr[ADDR_W-1:LANE_LSB];

  // Age of the held entry in cycles, and whether the slice has rotated
  // by one every cycle since it was loaded.
  always_ff @(posedge clk) begin
    prev_slice <= hub_slice;
    if (rst) begin
      steady_q <= 1'b0;
      age      <= '0;
    end else if (took) begin
      steady_q <= 1'b1;
      age      <= '0;
    end else begin
      steady_q <= steady_now;
      if (pending && age != {AGE_W{1'b1}}) age <= age + 1'b1;
    end
  end

  p_reset_clear_r10: assert property (@(posedge clk) rst |=> !pending && !commit);

  p_idle_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !pending && !rd_req) |-> !stall);

  p_busy_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_req && pending && !commit) |-> stall);

  p_hold_entry_r1: assert property (@(posedge clk) disable iff (rst)
    (pending && !commit) |=> pending && $stable(cm_addr) && $stable(cm_data) && $stable(cm_be));

  p_drain_r5: assert property (@(posedge clk) disable iff (rst)
    (commit && !took) |=> !pending);

  p_swap_r6: assert property (@(posedge clk) disable iff (rst)
    (commit && took) |=> pending && cm_addr == $past(wr_addr) && cm_data == $past(wr_data));

  p_fwd_full_r7: assert property (@(posedge clk) disable iff (rst)
    fwd_hit |-> (&cm_be) && pending && rd_same);

  p_partial_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && pending && rd_same && !(&cm_be)) |-> stall && !fwd_hit);

  p_rotation_r3: assert property (@(posedge clk) disable iff (rst)
    (pending && steady_now) |-> age < AGE_W'(NUM_SLICES));

endmodule

bind hub_post_wbuf pwb_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_SLICES(NUM_SLICES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_req   (wr_req),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .stall    (stall),
  .fwd_hit  (fwd_hit),
  .hub_slice(hub_slice),
  .commit   (commit),
  .cm_addr  (cm_addr),
  .cm_data  (cm_data),
  .cm_be    (cm_be),
  .pending  (pending)
);

// File: tb/hub_post_wbuf_test.sv
module hub_post_wbuf_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_req = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        rd_req = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        stall, fwd_hit, commit, pending;
  logic [31:0] fwd_data, cm_data;
  logic [15:0] cm_addr;
  logic [3:0]  cm_be;
  logic [3:0]  hub_slice = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic        m_pend = 0;
  logic [15:0] m_addr = '0;
  logic [31:0] m_data = '0;
  logic [3:0]  m_be = '0;
  bit          rotate = 1;

  always #4 clk = ~clk;

  hub_post_wbuf uut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_req(rd_req), .rd_addr(rd_addr), .stall(stall),
    .fwd_hit(fwd_hit), .fwd_data(fwd_data), .hub_slice(hub_slice), .commit(commit),
    .cm_addr(cm_addr), .cm_data(cm_data), .cm_be(cm_be), .pending(pending)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_commit(input logic [3:0] sl);
    return m_pend && (sl == m_addr[5:2]);
  endfunction

  function automatic logic word_match(input logic [15:0] a);
    return m_pend && (a[15:2] == m_addr[15:2]);
  endfunction

  // One clock: drive at negedge, check combinational outputs, update model.
  task automatic step(input logic w, input logic [15:0] wa, input logic [31:0] wd,
                      input logic [3:0] wbe, input logic r, input logic [15:0] ra,
                      output logic got_stall);
    logic c, rs, ws, fw, st, acc;
    @(negedge clk);
    wr_req = w; wr_addr = wa; wr_data = wd; wr_be = wbe;
    rd_req = r; rd_addr = ra;
    #1;
    c  = exp_commit(hub_slice);
    rs = r && word_match(ra) && !(&m_be);
    fw = r && word_match(ra) && (&m_be);
    ws = w && m_pend && !c;
    st = ws || rs;
    acc = w && !st;
    chk(pending == m_pend, "R1 pending", 64'(pending), 64'(m_pend));
    chk(commit == c, "R5 commit", 64'(commit), 64'(c));
    if (c) chk({cm_addr, cm_data, cm_be} == {m_addr, m_data, m_be}, "R5 commit fields",
               64'({cm_addr, cm_data, cm_be}), 64'({m_addr, m_data, m_be}));
    if (rs)              chk(stall == st, "R8 partial read stall", 64'(stall), 64'(st));
    else if (w && m_pend && c) chk(stall == st, "R6 swap on commit", 64'(stall), 64'(st));
    else if (w && m_pend) chk(stall == st, "R4 busy stall", 64'(stall), 64'(st));
    else if (w)           chk(stall == st, "R2 idle accept", 64'(stall), 64'(st));
    else                  chk(stall == st, "R9 no stall", 64'(stall), 64'(st));
    if (fw) begin
      chk(fwd_hit == 1'b1, "R7 fwd_hit", 64'(fwd_hit), 64'd1);
      chk(fwd_data == m_data, "R7 fwd_data", 64'(fwd_data), 64'(m_data));
    end else begin
      chk(fwd_hit == 1'b0, "R9 no fwd", 64'(fwd_hit), 64'd0);
    end
    got_stall = stall;
    if (acc) begin
      m_pend = 1; m_addr = wa; m_data = wd; m_be = wbe;
    end else if (c) begin
      m_pend = 0;
    end
    @(posedge clk);
    #1;
    hub_slice = rotate ? hub_slice + 4'd1 : 4'($urandom);
  endtask

  task automatic idle(input int n);
    logic s;
    for (int i = 0; i < n; i++) step(0, '0, '0, '0, 0, '0, s);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_req = 0; rd_req = 0;
    @(posedge clk); @(posedge clk);
    #1; rst = 0; m_pend = 0; hub_slice = '0;
    @(negedge clk);
    chk(pending == 1'b0, "R10 pending after reset", 64'(pending), 64'd0);
    chk(commit == 1'b0, "R10 commit after reset", 64'(commit), 64'd0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic s;
    logic [15:0] a;
    void'($urandom(32'h2C0FFEE1));
    do_reset();

    // Directed: write to slice 7 word, second write lands on commit cycle (R6).
    a = 16'h031C; // slice field [5:2] = 7
    step(1, a, 32'hA5A5_0001, 4'hF, 0, '0, s);
    while (hub_slice != 4'd7) begin
      // busy writes stall (R4), full-lane read forwards (R7)
      step(1, 16'h0040, 32'h1, 4'hF, 1, a, s);
    end
    step(1, 16'h0088, 32'hBEEF_0002, 4'h3, 0, '0, s); // R6
    // partial entry: read same word stalls (R8), other word misses (R9)
    step(0, '0, '0, '0, 1, 16'h008A, s);
    step(0, '0, '0, '0, 1, 16'h0090, s);
    idle(20);

    // R3: one write per rotation never stalls
    for (int k = 0; k < 40; k++) begin
      step(1, 16'($urandom), $urandom, 4'($urandom), 0, '0, s);
      chk(s == 1'b0, "R3 spaced write stalled", 64'(s), 64'd0);
      idle(15);
    end

    // Mid-run reset with an entry held
    step(1, 16'h0004, 32'h77, 4'hF, 0, '0, s);
    do_reset();

    // Random mix, rotating then random slice
    for (int ph = 0; ph < 2; ph++) begin
      rotate = (ph == 0);
      for (int i = 0; i < 3000; i++) begin
        logic w, r;
        logic [15:0] wa, ra;
        w  = ($urandom % 3) == 0;
        r  = ($urandom % 4) == 0;
        wa = {8'h00, 8'($urandom)};
        ra = (($urandom % 2) == 0) ? {m_addr[15:2], 2'($urandom)} : {8'h00, 8'($urandom)};
        step(w, wa, $urandom, 4'($urandom), r, ra, s);
      end
    end
    rotate = 1;
    idle(20);
    done = 1;
    report();
  end
endmodule